// File: doc/BRIEF.md
# Rectangular Frame-Memory Transfer Address Generator

This block copies a rectangle of 16-bit pixels between a 32-bit word stream and a frame memory of 1024 columns by 512 lines. A single-cycle start pulse supplies three things: a position word, a size word and a direction bit. The block then walks the rectangle in raster order. It issues one pixel access per granted memory cycle and forms the address as line times 1024 plus column.

In the write direction, each incoming word supplies two pixels. The lower halfword is written first. The word is consumed only when its last pixel has been accepted by the memory. In the read direction, pairs of fetched pixels are packed into words and handed out on a valid/ready port.

Gaps in the incoming data or in the memory grant stall the walk in place, so a line that is interrupted mid-way resumes at its next pixel. A one-cycle done pulse follows the final pixel. A start that arrives while a transfer is in flight abandons the old one and begins the new one.

Top module: `rect_xfer_agen`

## Requirements
- R1: The start column is position bits 9:0 and the start line is position bits 24:16. All other position bits are ignored. The first access goes to address line*1024 + column.
- R2: The rectangle width in pixels is size bits 9:0, and a value of 0 means 1024. Size bits 15:10 are ignored.
- R3: The rectangle height in lines is size bits 24:16, and a value of 0 means 512. Size bits 31:25 are ignored.
- R4: Pixels are visited left to right within a line, then line by line downward. The column wraps modulo 1024 and the line wraps modulo 512, so an access always stays inside the frame memory.
- R5: In the write direction, pixel k of the transfer takes bits 15:0 of its word when k is even and bits 31:16 when k is odd. `wready_o` is high exactly in the memory-granted cycle of an odd pixel or of the final pixel, so an odd total discards the upper half of the last word. `mem_we_o` is high for the whole write transfer.
- R6: A pixel is requested only when it can proceed: for a write only while `wvalid_i` is high, and for a read only while the output word is not full. Without `mem_gnt_i` the request and its address hold, and the walk position does not move.
- R7: In the read direction, `mem_rdata_i` is taken in the cycle its request is granted. The first pixel of each pair goes to `rdata_o` bits 15:0 and the second to bits 31:16. An odd final pixel leaves bits 31:16 at zero. `rvalid_o` rises once the pair is complete and holds `rdata_o` steady until `rready_i` is high.
- R8: `done_o` pulses for exactly one cycle, the cycle after the final pixel is granted. `busy_o` is high while pixels remain or a read word is still waiting.
- R9: A start during a transfer drops the old progress and the pending read word. The new rectangle then runs from its first pixel, and no done pulse is given for the abandoned transfer.
- R10: After reset the block is idle: no request, no `wready_o`, no `rvalid_o`, no `done_o`, `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer with the values below |
| start_pos_i | input | 32 | Position word (column, line) |
| start_size_i | input | 32 | Size word (width, height) |
| start_rd_i | input | 1 | 1: frame memory to stream, 0: stream to frame memory |
| wdata_i | input | 32 | Write stream word, two pixels |
| wvalid_i | input | 1 | Write stream word valid |
| wready_o | output | 1 | Write stream word consumed |
| rdata_o | output | 32 | Read stream word, two pixels |
| rvalid_o | output | 1 | Read stream word valid |
| rready_i | input | 1 | Read stream word taken |
| mem_req_o | output | 1 | Pixel access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 19 | Pixel address, line*1024 + column |
| mem_wdata_o | output | 16 | Pixel to write |
| mem_gnt_i | input | 1 | Memory accepts the access this cycle |
| mem_rdata_i | input | 16 | Pixel read, valid in the granted cycle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first transfers run with steady data and grants, using both even and odd pixel totals, which shows whether halfword order and the discarded upper half are right. A run with sparse `wvalid_i` and `mem_gnt_i` shows whether a stalled line resumes at the correct pixel. Rectangles placed at the bottom-right corner and with zero width or height fields expose any wrap or size-decode error. Reads with random `rready_i`, and a start issued in the middle of a write, check word packing, word holding and the abandonment of the old progress.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/rxf_geom.sv
module rxf_geom
  import rxf_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  xfer_dir_e        dir_i,
  input  logic [DW-1:0]    pos_i,
  input  logic [DW-1:0]    size_i,
  input  logic             step_i,
  output logic             active_o,
  output xfer_dir_e        dir_o,
  output logic [XW+YW-1:0] addr_o,
  output logic             last_o,
  output logic             done_o
);
  localparam int YLSB = DW / 2;

  logic            act_q, done_q;
  xfer_dir_e       dir_q;
  logic [XW-1:0]   x0_q, off_q, wm1_q, col;
  logic [YW-1:0]   y_q, rem_q;
  logic            row_end;

  logic unused_fields;
  assign unused_fields = ^{pos_i[DW-1:YLSB+YW], pos_i[YLSB-1:XW],
                           size_i[DW-1:YLSB+YW], size_i[YLSB-1:XW]};

  assign col      = x0_q + off_q;
  assign row_end  = (off_q == wm1_q);
  assign last_o   = act_q & row_end & (rem_q == '0);
  assign addr_o   = {y_q, col};
  assign active_o = act_q;
  assign dir_o    = dir_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      dir_q  <= DIR_WR;
      x0_q   <= '0;
      off_q  <= '0;
      wm1_q  <= '0;
      y_q    <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= step_i & last_o & ~start_i;
      if (start_i) begin
        act_q <= 1'b1;
        dir_q <= dir_i;
        x0_q  <= pos_i[XW-1:0];
        y_q   <= pos_i[YLSB +: YW];
        // field minus one, wrapped: zero encodes the full span
        wm1_q <= size_i[XW-1:0] - 1'b1;
        rem_q <= size_i[YLSB +: YW] - 1'b1;
        off_q <= '0;
      end else if (step_i && act_q) begin
        if (row_end) begin
          off_q <= '0;
          y_q   <= y_q + 1'b1;
          if (rem_q == '0) act_q <= 1'b0;
          else             rem_q <= rem_q - 1'b1;
        end else begin
          off_q <= off_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_wr.sv
module rxf_wr #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          wvalid_i,
  input  logic [2*PW-1:0] wdata_i,
  input  logic          gnt_i,
  input  logic          last_i,
  output logic          req_o,
  output logic [PW-1:0] pix_o,
  output logic          wready_o,
  output logic          step_o
);
  logic [1:0][PW-1:0] lanes;
  logic               hi_q;

  assign lanes    = wdata_i;
  assign req_o    = en_i & wvalid_i;
  assign step_o   = req_o & gnt_i;
  assign pix_o    = lanes[hi_q];
  assign wready_o = step_o & (hi_q | last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= 1'b0;
    else if (clr_i)   hi_q <= 1'b0;
    else if (step_o)  hi_q <= last_i ? 1'b0 : ~hi_q;
  end
endmodule

// File: rtl/rxf_rd.sv
module rxf_rd #(
  parameter int PW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            gnt_i,
  input  logic [PW-1:0]   pix_i,
  input  logic            last_i,
  input  logic            rready_i,
  output logic            req_o,
  output logic            step_o,
  output logic [2*PW-1:0] rdata_o,
  output logic            rvalid_o
);
  logic               hi_q, vld_q;
  logic [1:0][PW-1:0] word_q;

  assign req_o    = en_i & ~vld_q;
  assign step_o   = req_o & gnt_i;
  assign rdata_o  = word_q;
  assign rvalid_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      vld_q <= 1'b0;
    end else if (clr_i) begin
      hi_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      if (vld_q && rready_i) vld_q <= 1'b0;
      if (step_o) begin
        if (hi_q || last_i) vld_q <= 1'b1;
        hi_q <= last_i ? 1'b0 : ~hi_q;
      end
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic load, zero;
    assign load = step_o && (hi_q == l[0]);
    // odd tail: upper lane cleared when the last pixel lands low
    assign zero = (l == 1) && step_o && !hi_q && last_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   word_q[l] <= '0;
      else if (load) word_q[l] <= pix_i;
      else if (zero) word_q[l] <= '0;
    end
  end
endmodule

// File: rtl/rect_xfer_agen.sv
module rect_xfer_agen
  import rxf_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int PW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2*PW-1:0]  start_pos_i,
  input  logic [2*PW-1:0]  start_size_i,
  input  logic             start_rd_i,
  input  logic [2*PW-1:0]  wdata_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  output logic [2*PW-1:0]  rdata_o,
  output logic             rvalid_o,
  input  logic             rready_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XW+YW-1:0] mem_addr_o,
  output logic [PW-1:0]    mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic [PW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int DW = 2 * PW;

  xfer_dir_e dir_in, dir;
  logic      active, last, step;
  logic      en_wr, en_rd;
  logic      wr_req, wr_step, rd_req, rd_step;

  assign dir_in = start_rd_i ? DIR_RD : DIR_WR;
  assign en_wr  = active & (dir == DIR_WR);
  assign en_rd  = active & (dir == DIR_RD);
  assign step   = wr_step | rd_step;

  rxf_geom #(.XW(XW), .YW(YW), .DW(DW)) u_geom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .dir_i   (dir_in),
    .pos_i   (start_pos_i),
    .size_i  (start_size_i),
    .step_i  (step),
    .active_o(active),
    .dir_o   (dir),
    .addr_o  (mem_addr_o),
    .last_o  (last),
    .done_o  (done_o)
  );

  rxf_wr #(.PW(PW)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .en_i    (en_wr),
    .wvalid_i(wvalid_i),
    .wdata_i (wdata_i),
    .gnt_i   (mem_gnt_i),
    .last_i  (last),
    .req_o   (wr_req),
    .pix_o   (mem_wdata_o),
    .wready_o(wready_o),
    .step_o  (wr_step)
  );

  rxf_rd #(.PW(PW)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .en_i    (en_rd),
    .gnt_i   (mem_gnt_i),
    .pix_i   (mem_rdata_i),
    .last_i  (last),
    .rready_i(rready_i),
    .req_o   (rd_req),
    .step_o  (rd_step),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  assign mem_req_o = wr_req | rd_req;
  assign mem_we_o  = en_wr;
  assign busy_o    = active | rvalid_o;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int AW = 19,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_gnt_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          wready_o,
  input logic          rvalid_o,
  input logic          rready_i,
  input logic [DW-1:0] rdata_o,
  input logic          busy_o,
  input logic          done_o
);
  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i && !start_i |=> $stable(mem_addr_o));

  // R7
  rword_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i && !start_i |=> rvalid_o && $stable(rdata_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  wready_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> mem_req_o && mem_gnt_i && mem_we_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !wready_o);
endmodule

bind rect_xfer_agen rxf_chk #(.AW(XW + YW), .DW(2 * PW)) u_chk (.*);

// File: tb/tb_rect_xfer_agen.sv
`timescale 1ns/1ps
module tb_rect_xfer_agen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_pos_i = '0, start_size_i = '0;
  logic        start_rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        wvalid_i = 1'b0;
  logic        wready_o;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic        rready_i = 1'b0;
  logic        mem_req_o, mem_we_o;
  logic [18:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_gnt_i = 1'b0;
  logic [15:0] mem_rdata_i;
  logic        busy_o, done_o;

  always #2.5 clk_i = ~clk_i;

  rect_xfer_agen dut (.*);

  function automatic logic [15:0] pix_of(input logic [18:0] a);
    logic [31:0] t;
    t = {13'b0, a} * 32'd40503 + 32'd17;
    return t[15:0] ^ t[31:16];
  endfunction
  assign mem_rdata_i = pix_of(mem_addr_o);

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  bit    m_act = 0, m_rd = 0, m_rv = 0, m_done = 0;
  int    m_x0 = 0, m_y0 = 0, m_w = 1, m_h = 1, m_n = 0, m_cnt = 0;
  logic [15:0] m_lo = '0, m_hi = '0;
  int    gnt_pct = 100, wv_pct = 100, rr_pct = 100;
  bit    chk_en = 0, hs = 0;
  int    done_seen = 0;

  int          e_addr;
  bit          e_last, e_req, e_we, e_wready, e_busy;
  logic [15:0] e_wdata;
  always_comb begin
    e_addr   = ((m_y0 + m_n / m_w) % 512) * 1024 + (m_x0 + m_n % m_w) % 1024;
    e_last   = (m_n == m_w * m_h - 1);
    e_we     = m_act && !m_rd;
    e_req    = m_act && (m_rd ? !m_rv : wvalid_i);
    e_wready = e_we && wvalid_i && mem_gnt_i && ((m_n % 2 == 1) || e_last);
    e_wdata  = (m_n % 2 == 1) ? wdata_i[31:16] : wdata_i[15:0];
    e_busy   = m_act || m_rv;
  end

  always @(posedge clk_i) begin
    bit step, last, dn;
    int a;
    step = e_req && mem_gnt_i;
    last = e_last;
    a    = e_addr;
    dn   = step && last && !start_i;
    if (m_rv && rready_i) m_rv = 0;
    if (step) begin
      if (m_rd) begin
        if (m_n % 2 == 0) begin
          m_lo = pix_of(19'(a));
          if (last) begin m_hi = '0; m_rv = 1; end
        end else begin
          m_hi = pix_of(19'(a));
          m_rv = 1;
        end
      end
      m_n++;
      m_cnt++;
      if (last) m_act = 0;
    end
    if (start_i) begin
      m_act = 1;
      m_rd  = start_rd_i;
      m_rv  = 0;
      m_x0  = int'(start_pos_i[9:0]);
      m_y0  = int'(start_pos_i[24:16]);
      m_w   = ((int'(start_size_i) - 1) & 'h3ff) + 1;
      m_h   = (((int'(start_size_i >> 16)) - 1) & 'h1ff) + 1;
      m_n   = 0;
      m_cnt = 0;
    end
    m_done = dn;
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (chk_en) begin
      chk(busy_o === e_busy, "R8 busy", busy_o, e_busy);
      chk(done_o === m_done, "R8 done", done_o, m_done);
      chk(mem_req_o === e_req, "R6 req", mem_req_o, e_req);
      if (e_req) begin
        chk(mem_addr_o === 19'(e_addr), "R1/R4 addr", mem_addr_o, e_addr);
        chk(mem_we_o === e_we, "R5 we", mem_we_o, e_we);
        if (e_we) chk(mem_wdata_o === e_wdata, "R5 wdata", mem_wdata_o, e_wdata);
      end
      chk(wready_o === e_wready, "R5 wready", wready_o, e_wready);
      chk(rvalid_o === m_rv, "R7 rvalid", rvalid_o, m_rv);
      if (m_rv) chk(rdata_o === {m_hi, m_lo}, "R7 rdata", rdata_o, {m_hi, m_lo});
      if (done_o) done_seen++;
    end
    hs = wvalid_i && wready_o;
  end

  // random handshake driver
  always @(posedge clk_i) begin
    #1;
    mem_gnt_i = ($urandom % 100) < gnt_pct;
    rready_i  = ($urandom % 100) < rr_pct;
    if (!wvalid_i || hs) begin
      wvalid_i = ($urandom % 100) < wv_pct;
      wdata_i  = $urandom;
    end
  end

  task automatic kick(input logic [31:0] pos, input logic [31:0] size, input bit rd);
    @(posedge clk_i); #1;
    start_i = 1'b1; start_pos_i = pos; start_size_i = size; start_rd_i = rd;
    done_seen = 0;
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  task automatic run(input logic [31:0] pos, input logic [31:0] size, input bit rd,
                     input int gp, input int wp, input int rp, input string tag);
    int w, h;
    gnt_pct = gp; wv_pct = wp; rr_pct = rp;
    kick(pos, size, rd);
    while (m_act || m_rv) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
    w = (size[9:0] == 0) ? 1024 : int'(size[9:0]);
    h = (size[24:16] == 0) ? 512 : int'(size[24:16]);
    chk(m_cnt == w * h, {tag, " pixel count"}, m_cnt, w * h);
    chk(done_seen == 1, {tag, " R8 one done"}, done_seen, 1);
    chk(busy_o === 1'b0, {tag, " R8 idle after"}, busy_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(busy_o === 1'b0,    "R10 busy",   busy_o, 0);
    chk(mem_req_o === 1'b0, "R10 req",    mem_req_o, 0);
    chk(wready_o === 1'b0,  "R10 wready", wready_o, 0);
    chk(rvalid_o === 1'b0,  "R10 rvalid", rvalid_o, 0);
    chk(done_o === 1'b0,    "R10 done",   done_o, 0);
    chk_en = 1;
    run(32'h0007_0005, 32'h0002_0003, 0, 100, 100, 100, "R1");
    run(32'h0020_0010, 32'h0001_0003, 0, 100, 100, 100, "R5");
    run(32'h0030_0100, 32'h0003_0005, 0, 60, 50, 100, "R6");
    run(32'h01FF_03FE, 32'h0002_0004, 0, 100, 100, 100, "R4");
    run(32'h0010_0040, 32'h0002_0000, 0, 90, 95, 100, "R2");
    run(32'h0100_0200, 32'h0000_0001, 0, 90, 95, 100, "R3");
    run(32'h0004_0008, 32'h0003_0003, 1, 70, 100, 50, "R7");
    run(32'h0001_0001, 32'h0001_0001, 1, 100, 100, 30, "R7 odd");
    run(32'hAE05_F402, 32'hC802_7C04, 1, 80, 100, 80, "R1 junk");
    // R9 restart mid-transfer
    gnt_pct = 100; wv_pct = 100; rr_pct = 100;
    kick(32'h0000_0000, 32'h0008_0008, 0);
    repeat (10) @(posedge clk_i);
    run(32'h0050_0060, 32'h0002_0002, 1, 100, 100, 100, "R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule